// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block models a NOR-style parallel flash: a small byte array behind a simple memory-mapped bus. Bus writes are read as commands or as data. Which one depends on a write-cycle index and on the command that is currently latched. Together these two values also decide what a bus read returns: array contents, the status byte, identifier codes or bytes from a built-in query table. The supported operations are single program, sector erase with confirm, a counted buffered write, status read and clear, identifier read, query mode, and lock/unlock sequences. Each of these completes in the same cycle it is written, so status bit 7 reports ready at once.

A host issues a command byte in the low lane of a write, then supplies data or a confirm in later writes. It polls status with an ordinary read. A `readOnly` input stops every change to storage and reports the refused operation through error bits in the status byte. Accesses are 1, 2 or 4 bytes wide. A parameter picks the byte order used for multi-byte data.

Top module: `flash_seq`

## Requirements
- R1: After reset, status is 0x00, the device is in read-array mode, and every storage byte reads 0xFF.
- R2: Writing 0x10 or 0x40 arms single program. The next write stores its data at its address and returns to cycle 0. Reads then return status with bit 7 set.
- R3: 0x20 or 0x28 followed by 0xD0 sets every byte of the sector holding the confirm address (address aligned down to SECTOR_BYTES) to 0xFF. A second write of any other value leaves storage unchanged and returns to read-array mode.
- R4: 0xE8 starts a buffered write. The next write gives a count N, the following N+1 writes store data, and a final 0xD0 completes it. Reads return status during the sequence. A value other than 0xD0 in the confirm slot returns to read-array mode.
- R5: Status bit 7 is ready. Bit 4 reports a refused program and bit 5 a refused erase. While readOnly is 1, storage never changes.
- R6: 0x50 clears the whole status byte and returns to read-array mode. 0xFF, 0xF0 and 0x00 return to read-array mode.
- R7: After 0x70, reads return the status byte SS. A 1- or 2-byte read gives it zero-extended. A 4-byte read gives 0x00SS00SS.
- R8: After 0x90, reads use index = address / LANES. Index 0 returns {ID0,ID1}, index 1 returns {ID2,ID3}, and any other index returns 0.
- R9: After 0x98, reads use index = address / LANES into the query table. Indices 0x10, 0x11 and 0x12 hold 0x51, 0x52, 0x59. Indices above 0x52 read 0. A write of 0xFF leaves query mode. Any other write keeps it.
- R10: 0x60 followed by 0xD0 or 0x01 completes with status bit 7 set, and reads return status. Any other second value returns to read-array mode.
- R11: accSize 0, 1 and 2 select 1-, 2- and 4-byte accesses. With BIG_END=0 (the default), the byte at the access address sits in bits 7:0.
- R12: An unrecognised command byte in cycle 0 returns to read-array mode without touching storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| readOnly | input | 1 | Blocks all storage changes |
| wrEn | input | 1 | Single-cycle write strobe |
| addr | input | ADDR_W | Byte address of the access |
| accSize | input | 2 | 0: 1 byte, 1: 2 bytes, 2: 4 bytes |
| wrData | input | 32 | Write data, command byte in bits 7:0 |
| rdData | output | 32 | Combinational read data |

## Verification
Every command is driven after setup writes that put known values in storage. This lets a read show both the mode, by telling array bytes apart from status, identifier or query values, and whether storage changed. Each sequence is tried with its accepted confirm and with a rejected one, so a missing abort shows up as a stale mode or an unwanted change. Status is read at all three widths to separate the mirrored 4-byte form from the plain form. The read-only runs set distinct error bits, so the mirrored word changes with the error set.

// File: rtl/flashseq_pkg.sv
package flashseq_pkg;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_STATUS = 2'd1,
    RD_IDENT  = 2'd2,
    RD_QUERY  = 2'd3
  } rdmode_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic       dataWr;
    logic       blkErase;
    rdmode_e    rdMode;
    logic [7:0] statusByte;
  } ctrl_strobe_t;

  localparam logic [7:0] OP_RESET0   = 8'h00;
  localparam logic [7:0] OP_PROG_A   = 8'h10;
  localparam logic [7:0] OP_ERASE_A  = 8'h20;
  localparam logic [7:0] OP_ERASE_B  = 8'h28;
  localparam logic [7:0] OP_PROG_B   = 8'h40;
  localparam logic [7:0] OP_CLRSTAT  = 8'h50;
  localparam logic [7:0] OP_LOCK     = 8'h60;
  localparam logic [7:0] OP_STATUS   = 8'h70;
  localparam logic [7:0] OP_IDENT    = 8'h90;
  localparam logic [7:0] OP_QUERY    = 8'h98;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_UNLOCK1  = 8'h01;
  localparam logic [7:0] OP_BUFWR    = 8'hE8;
  localparam logic [7:0] OP_RESETF0  = 8'hF0;
  localparam logic [7:0] OP_RESETFF  = 8'hFF;

  localparam logic [7:0] ST_READY    = 8'h80;
  localparam logic [7:0] ST_ERASEERR = 8'h20;
  localparam logic [7:0] ST_PROGERR  = 8'h10;

  localparam int QUERY_LEN = 'h52;

endpackage

// File: rtl/flash_query_rom.sv
module flash_query_rom
  import flashseq_pkg::*;
#(
  parameter int DEPTH_BYTES  = 512,
  parameter int SECTOR_BYTES = 64,
  parameter int LANES        = 4,
  parameter int ADDR_W       = $clog2(DEPTH_BYTES)
) (
  input  logic [ADDR_W-1:0] idx,
  output logic [7:0]        qByte
);
  localparam logic [7:0]  DEV_LOG2 = 8'($clog2(DEPTH_BYTES));
  localparam logic [7:0]  BUF_LOG2 = (LANES == 1) ? 8'd8 : 8'd11;
  localparam logic [15:0] NBLK_M1  = 16'(DEPTH_BYTES / SECTOR_BYTES - 1);
  localparam logic [23:0] SEC_SZ   = 24'(SECTOR_BYTES);
  localparam logic [ADDR_W-1:0] QLEN = ADDR_W'(QUERY_LEN);

  always_comb begin
    qByte = 8'h00;
    if (idx <= QLEN) begin
      case (idx[6:0])
        7'h10: qByte = 8'h51;
        7'h11: qByte = 8'h52;
        7'h12: qByte = 8'h59;
        7'h13: qByte = 8'h01;
        7'h15: qByte = 8'h31;
        7'h1B: qByte = 8'h45;
        7'h1C: qByte = 8'h55;
        7'h1F: qByte = 8'h07;
        7'h20: qByte = 8'h07;
        7'h21: qByte = 8'h0A;
        7'h23: qByte = 8'h04;
        7'h24: qByte = 8'h04;
        7'h25: qByte = 8'h04;
        7'h27: qByte = DEV_LOG2;
        7'h28: qByte = 8'h02;
        7'h2A: qByte = BUF_LOG2;
        7'h2C: qByte = 8'h01;
        7'h2D: qByte = NBLK_M1[7:0];
        7'h2E: qByte = NBLK_M1[15:8];
        7'h2F: qByte = SEC_SZ[15:8];
        7'h30: qByte = SEC_SZ[23:16];
        7'h31: qByte = 8'h50;
        7'h32: qByte = 8'h52;
        7'h33: qByte = 8'h49;
        7'h34: qByte = 8'h31;
        7'h35: qByte = 8'h30;
        7'h3F: qByte = 8'h01;
        default: qByte = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flashseq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             readOnly,
  input  logic             wrEn,
  input  logic [CNT_W-1:0] wrData,
  output ctrl_strobe_t     strb
);
  logic [1:0]       cycle, cycleNext;
  logic [7:0]       cmd, cmdNext;
  logic [7:0]       status, statusNext;
  logic [CNT_W-1:0] count, countNext;
  logic             doWrite, doErase, goArray;
  logic [7:0]       opByte;

  assign opByte = wrData[7:0];

  always_comb begin
    cycleNext  = cycle;
    cmdNext    = cmd;
    statusNext = status;
    countNext  = count;
    doWrite    = 1'b0;
    doErase    = 1'b0;
    goArray    = 1'b0;
    if (wrEn) begin
      case (cycle)
        2'd0: begin
          case (opByte)
            OP_RESET0, OP_RESETF0, OP_RESETFF: goArray = 1'b1;
            OP_PROG_A, OP_PROG_B, OP_ERASE_A, OP_ERASE_B, OP_LOCK, OP_QUERY: begin
              cycleNext = 2'd1;
              cmdNext   = opByte;
            end
            OP_CLRSTAT: begin
              statusNext = 8'h00;
              goArray    = 1'b1;
            end
            OP_STATUS, OP_IDENT: cmdNext = opByte;
            OP_BUFWR: begin
              statusNext = status | ST_READY;
              cycleNext  = 2'd1;
              cmdNext    = opByte;
            end
            default: goArray = 1'b1;
          endcase
        end
        2'd1: begin
          case (cmd)
            OP_PROG_A, OP_PROG_B: begin
              if (readOnly) statusNext = status | ST_PROGERR | ST_READY;
              else begin
                doWrite    = 1'b1;
                statusNext = status | ST_READY;
              end
              cycleNext = 2'd0;
            end
            OP_ERASE_A, OP_ERASE_B: begin
              if (opByte == OP_CONFIRM) begin
                if (readOnly) statusNext = status | ST_ERASEERR | ST_READY;
                else begin
                  doErase    = 1'b1;
                  statusNext = status | ST_READY;
                end
                cycleNext = 2'd0;
              end else goArray = 1'b1;
            end
            OP_BUFWR: begin
              countNext = wrData;
              cycleNext = 2'd2;
            end
            OP_LOCK: begin
              if (opByte == OP_CONFIRM || opByte == OP_UNLOCK1) begin
                statusNext = status | ST_READY;
                cycleNext  = 2'd0;
              end else goArray = 1'b1;
            end
            OP_QUERY: begin
              if (opByte == OP_RESETFF) goArray = 1'b1;
            end
            default: goArray = 1'b1;
          endcase
        end
        2'd2: begin
          if (cmd == OP_BUFWR) begin
            if (readOnly) statusNext = status | ST_PROGERR | ST_READY;
            else begin
              doWrite    = 1'b1;
              statusNext = status | ST_READY;
            end
            if (count == '0) cycleNext = 2'd3;
            else countNext = count - 1'b1;
          end else goArray = 1'b1;
        end
        default: begin
          if (cmd == OP_BUFWR && opByte == OP_CONFIRM) begin
            statusNext = status | ST_READY;
            cycleNext  = 2'd0;
          end else goArray = 1'b1;
        end
      endcase
      if (goArray) begin
        cycleNext = 2'd0;
        cmdNext   = OP_RESET0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycle  <= 2'd0;
      cmd    <= OP_RESET0;
      status <= 8'h00;
      count  <= '0;
    end else begin
      cycle  <= cycleNext;
      cmd    <= cmdNext;
      status <= statusNext;
      count  <= countNext;
    end
  end

  rdmode_e mode;
  always_comb begin
    case (cmd)
      OP_IDENT: mode = RD_IDENT;
      OP_QUERY: mode = RD_QUERY;
      OP_PROG_A, OP_PROG_B, OP_ERASE_A, OP_ERASE_B, OP_CLRSTAT,
      OP_LOCK, OP_STATUS, OP_BUFWR: mode = RD_STATUS;
      default: mode = RD_ARRAY;
    endcase
  end

  assign strb.dataWr     = doWrite;
  assign strb.blkErase   = doErase;
  assign strb.rdMode     = mode;
  assign strb.statusByte = status;

  // R5: storage strobes never fire while read-only
  a_r5_ro_blocks: assert property (@(posedge clk) disable iff (!rstN)
    readOnly |-> !(strb.dataWr || strb.blkErase));

  // R4: the data and confirm cycles belong only to the buffered write
  a_r4_burst_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (cycle >= 2'd2) |-> (cmd == OP_BUFWR));

  // R2: a completed single program leaves ready set and cycle 0
  a_r2_ready_after_prog: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cycle == 2'd1 && (cmd == OP_PROG_A || cmd == OP_PROG_B))
      |=> (status[7] && cycle == 2'd0));

  // R6: the clear command empties status and goes to read-array mode
  a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cycle == 2'd0 && opByte == OP_CLRSTAT)
      |=> (status == 8'h00 && mode == RD_ARRAY));

  // R12: an unknown first-cycle byte yields read-array mode, no storage strobe
  a_r12_unknown: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cycle == 2'd0 && opByte == 8'h33)
      |-> (!strb.dataWr && !strb.blkErase) ##1 (mode == RD_ARRAY));
endmodule

// File: rtl/flash_store.sv
module flash_store
  import flashseq_pkg::*;
#(
  parameter int          DEPTH_BYTES  = 512,
  parameter int          SECTOR_BYTES = 64,
  parameter int          LANES        = 4,
  parameter bit          BIG_END      = 1'b0,
  parameter logic [7:0]  ID0          = 8'h12,
  parameter logic [7:0]  ID1          = 8'h34,
  parameter logic [7:0]  ID2          = 8'h56,
  parameter logic [7:0]  ID3          = 8'h78,
  parameter int          ADDR_W       = $clog2(DEPTH_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        accSize,
  input  logic [31:0]       wrData,
  input  logic [7:0]        qByte,
  output logic [ADDR_W-1:0] infoIdx,
  output logic [31:0]       rdData
);
  localparam int SEC_SHIFT  = $clog2(SECTOR_BYTES);
  localparam int LANE_SHIFT = $clog2(LANES);

  logic [7:0]        mem [DEPTH_BYTES];
  logic [ADDR_W-1:0] laneAddr [4];
  logic [7:0]        laneVal  [4];
  logic [3:0]        laneEn;
  int                nBytes;

  assign nBytes  = (accSize == 2'd0) ? 1 : (accSize == 2'd1) ? 2 : 4;
  assign infoIdx = addr >> LANE_SHIFT;

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign laneAddr[k] = addr + ADDR_W'(k);
    assign laneEn[k]   = (k < nBytes);
    if (BIG_END) begin : g_be
      always_comb begin
        laneVal[k] = 8'h00;
        for (int s = 0; s < 4; s++)
          if (s == nBytes - 1 - k) laneVal[k] = wrData[8*s +: 8];
      end
    end else begin : g_le
      assign laneVal[k] = wrData[8*k +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH_BYTES; i++) mem[i] <= 8'hFF;
    end else if (strb.blkErase) begin
      for (int i = 0; i < DEPTH_BYTES; i++)
        if ((ADDR_W'(i) >> SEC_SHIFT) == (addr >> SEC_SHIFT)) mem[i] <= 8'hFF;
    end else if (strb.dataWr) begin
      for (int k = 0; k < 4; k++)
        if (laneEn[k]) mem[laneAddr[k]] <= laneVal[k];
    end
  end

  logic [31:0] arrWord;
  always_comb begin
    arrWord = 32'h0;
    for (int k = 0; k < 4; k++) begin
      if (k < nBytes) begin
        if (BIG_END) begin
          for (int p = 0; p < 4; p++)
            if (p == nBytes - 1 - k) arrWord[8*p +: 8] = mem[laneAddr[k]];
        end else begin
          arrWord[8*k +: 8] = mem[laneAddr[k]];
        end
      end
    end
  end

  always_comb begin
    case (strb.rdMode)
      RD_STATUS: rdData = (nBytes == 4) ? {8'h00, strb.statusByte, 8'h00, strb.statusByte}
                                        : {24'h0, strb.statusByte};
      RD_IDENT: begin
        if (infoIdx == '0)                  rdData = {16'h0, ID0, ID1};
        else if (infoIdx == ADDR_W'(1))     rdData = {16'h0, ID2, ID3};
        else                                rdData = 32'h0;
      end
      RD_QUERY: rdData = {24'h0, qByte};
      default:  rdData = arrWord;
    endcase
  end

  // R3: after an erase strobe the first and last byte of the sector are blank
  a_r3_erase_fills: assert property (@(posedge clk) disable iff (!rstN)
    strb.blkErase |=> (mem[($past(addr) >> SEC_SHIFT) << SEC_SHIFT] == 8'hFF &&
                       mem[(($past(addr) >> SEC_SHIFT) << SEC_SHIFT) + ADDR_W'(SECTOR_BYTES-1)] == 8'hFF));

  // R2: a data strobe lands its first lane at the access address
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataWr && !strb.blkErase && !BIG_END)
      |=> (mem[$past(addr)] == $past(wrData[7:0])));

  // R7: a wide status read carries two copies of the status byte
  a_r7_status_mirror: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdMode == RD_STATUS && accSize == 2'd2)
      |-> (rdData[23:16] == strb.statusByte && rdData[7:0] == strb.statusByte &&
           rdData[31:24] == 8'h00 && rdData[15:8] == 8'h00));
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flashseq_pkg::*;
#(
  parameter int          DEPTH_BYTES  = 512,
  parameter int          SECTOR_BYTES = 64,
  parameter int          LANES        = 4,
  parameter bit          BIG_END      = 1'b0,
  parameter int          CNT_W        = 16,
  parameter logic [7:0]  ID0          = 8'h12,
  parameter logic [7:0]  ID1          = 8'h34,
  parameter logic [7:0]  ID2          = 8'h56,
  parameter logic [7:0]  ID3          = 8'h78,
  localparam int         ADDR_W       = $clog2(DEPTH_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              readOnly,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        accSize,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData
);
  ctrl_strobe_t      strb;
  logic [ADDR_W-1:0] infoIdx;
  logic [7:0]        qByte;

  flash_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .readOnly(readOnly), .wrEn(wrEn),
    .wrData(wrData[CNT_W-1:0]), .strb(strb)
  );

  flash_store #(
    .DEPTH_BYTES(DEPTH_BYTES), .SECTOR_BYTES(SECTOR_BYTES), .LANES(LANES),
    .BIG_END(BIG_END), .ID0(ID0), .ID1(ID1), .ID2(ID2), .ID3(ID3), .ADDR_W(ADDR_W)
  ) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .accSize(accSize),
    .wrData(wrData), .qByte(qByte), .infoIdx(infoIdx), .rdData(rdData)
  );

  flash_query_rom #(
    .DEPTH_BYTES(DEPTH_BYTES), .SECTOR_BYTES(SECTOR_BYTES), .LANES(LANES), .ADDR_W(ADDR_W)
  ) u_query (
    .idx(infoIdx), .qByte(qByte)
  );
endmodule

// File: tb/sim_flash_seq.sv
module sim_flash_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        readOnly = 1'b0;
  logic        wrEn = 1'b0;
  logic [8:0]  addr = '0;
  logic [1:0]  accSize = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] refMem [512];

  always #5 clk = ~clk;

  flash_seq u0 (
    .clk(clk), .rstN(rstN), .readOnly(readOnly), .wrEn(wrEn),
    .addr(addr), .accSize(accSize), .wrData(wrData), .rdData(rdData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // size: 0=1 byte, 1=2 bytes, 2=4 bytes
  task automatic busWr(input logic [8:0] a, input logic [31:0] d, input logic [1:0] sz);
    @(negedge clk);
    addr = a; wrData = d; accSize = sz; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic cmdWr(input logic [8:0] a, input logic [7:0] c);
    busWr(a, {24'h0, c}, 2'd0);
  endtask

  task automatic busRd(input logic [8:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    addr = a; accSize = sz;
    #1 d = rdData;
  endtask

  task automatic refWr(input logic [8:0] a, input logic [31:0] d, input int n);
    for (int k = 0; k < n; k++) refMem[9'(a + 9'(k))] = d[8*k +: 8];
  endtask

  function automatic logic [31:0] ref32(input logic [8:0] a);
    return {refMem[9'(a+9'd3)], refMem[9'(a+9'd2)], refMem[9'(a+9'd1)], refMem[a]};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    busRd(9'h000, 2'd2, v); chk("R1 blank array", v, 32'hFFFF_FFFF);
    busRd(9'h1FC, 2'd2, v); chk("R1 blank top", v, 32'hFFFF_FFFF);
    cmdWr(9'h0, 8'h70);
    busRd(9'h0, 2'd0, v); chk("R1 status zero", v, 32'h0);
    cmdWr(9'h0, 8'hFF);
  endtask

  task automatic t_program();
    logic [31:0] v;
    cmdWr(9'h010, 8'h40); busWr(9'h010, 32'h0000_00A5, 2'd0); refWr(9'h010, 32'hA5, 1);
    busRd(9'h010, 2'd0, v); chk("R2 status after program", v, 32'h80);
    cmdWr(9'h0, 8'hFF);
    busRd(9'h010, 2'd0, v); chk("R2 byte stored", v, 32'hA5);
    cmdWr(9'h020, 8'h10); busWr(9'h020, 32'h1122_3344, 2'd2); refWr(9'h020, 32'h11223344, 4);
    cmdWr(9'h0, 8'hFF);
    busRd(9'h020, 2'd2, v); chk("R2 word stored", v, ref32(9'h020));
    busRd(9'h020, 2'd0, v); chk("R11 low byte first", v, 32'h44);
    busRd(9'h022, 2'd1, v); chk("R11 half read", v, 32'h1122);
    cmdWr(9'h044, 8'h10); busWr(9'h044, 32'hDEAD_BEEF, 2'd2); refWr(9'h044, 32'hDEADBEEF, 4);
    cmdWr(9'h0, 8'hFF);
  endtask

  task automatic t_erase();
    logic [31:0] v;
    cmdWr(9'h050, 8'h20); cmdWr(9'h050, 8'hFF);
    busRd(9'h044, 2'd2, v); chk("R3 abort by FF keeps data", v, 32'hDEAD_BEEF);
    cmdWr(9'h050, 8'h20); cmdWr(9'h050, 8'h12);
    busRd(9'h044, 2'd2, v); chk("R3 bad confirm keeps data", v, 32'hDEAD_BEEF);
    cmdWr(9'h050, 8'h28); cmdWr(9'h050, 8'hD0);
    for (int i = 64; i < 128; i++) refMem[i] = 8'hFF;
    busRd(9'h050, 2'd0, v); chk("R3 ready after erase", v, 32'h80);
    cmdWr(9'h0, 8'hFF);
    busRd(9'h044, 2'd2, v); chk("R3 sector blank", v, 32'hFFFF_FFFF);
    busRd(9'h040, 2'd2, v); chk("R3 sector base blank", v, 32'hFFFF_FFFF);
    busRd(9'h020, 2'd2, v); chk("R3 other sector kept", v, ref32(9'h020));
  endtask

  task automatic t_buffer();
    logic [31:0] v;
    cmdWr(9'h0, 8'h50);
    cmdWr(9'h080, 8'hE8);
    busWr(9'h080, 32'd2, 2'd2);
    busWr(9'h080, 32'hCAFE_0001, 2'd2); refWr(9'h080, 32'hCAFE0001, 4);
    busRd(9'h080, 2'd0, v); chk("R4 status mid burst", v, 32'h80);
    busWr(9'h084, 32'hCAFE_0002, 2'd2); refWr(9'h084, 32'hCAFE0002, 4);
    busWr(9'h088, 32'hCAFE_0003, 2'd2); refWr(9'h088, 32'hCAFE0003, 4);
    cmdWr(9'h080, 8'hD0);
    busRd(9'h080, 2'd0, v); chk("R4 status after confirm", v, 32'h80);
    cmdWr(9'h0, 8'hFF);
    busRd(9'h080, 2'd2, v); chk("R4 word0", v, ref32(9'h080));
    busRd(9'h088, 2'd2, v); chk("R4 word2", v, ref32(9'h088));
    busRd(9'h08C, 2'd2, v); chk("R4 no extra word", v, 32'hFFFF_FFFF);
    cmdWr(9'h090, 8'hE8); busWr(9'h090, 32'd0, 2'd2);
    busWr(9'h090, 32'h5555_AAAA, 2'd2); refWr(9'h090, 32'h5555AAAA, 4);
    cmdWr(9'h090, 8'h33);
    busRd(9'h090, 2'd2, v); chk("R4 bad confirm gives array", v, ref32(9'h090));
  endtask

  task automatic t_clear();
    logic [31:0] v;
    cmdWr(9'h0, 8'h50); cmdWr(9'h0, 8'h70);
    busRd(9'h0, 2'd0, v); chk("R6 clear empties status", v, 32'h0);
    cmdWr(9'h0, 8'hF0);
    busRd(9'h010, 2'd0, v); chk("R6 F0 to array", v, 32'hA5);
    cmdWr(9'h0, 8'h70); cmdWr(9'h0, 8'h00);
    busRd(9'h010, 2'd0, v); chk("R6 00 to array", v, 32'hA5);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    cmdWr(9'h0, 8'h50);
    cmdWr(9'h0, 8'h60); cmdWr(9'h0, 8'h01);
    busRd(9'h0, 2'd0, v); chk("R10 unlock ready", v, 32'h80);
    cmdWr(9'h0, 8'h60); cmdWr(9'h0, 8'hD0);
    busRd(9'h0, 2'd0, v); chk("R10 lock ready", v, 32'h80);
    cmdWr(9'h0, 8'h60); cmdWr(9'h0, 8'h55);
    busRd(9'h010, 2'd0, v); chk("R10 bad value to array", v, 32'hA5);
  endtask

  task automatic t_readonly();
    logic [31:0] v;
    cmdWr(9'h0, 8'h50);
    readOnly = 1'b1;
    cmdWr(9'h010, 8'h10); busWr(9'h010, 32'h0, 2'd0);
    busRd(9'h010, 2'd0, v); chk("R5 program error bit", v, 32'h90);
    cmdWr(9'h0, 8'hFF);
    busRd(9'h010, 2'd0, v); chk("R5 program refused", v, 32'hA5);
    cmdWr(9'h020, 8'h20); cmdWr(9'h020, 8'hD0);
    busRd(9'h020, 2'd0, v); chk("R5 erase error bit", v, 32'hB0);
    cmdWr(9'h0, 8'hFF);
    busRd(9'h020, 2'd2, v); chk("R5 erase refused", v, ref32(9'h020));
    readOnly = 1'b0;
  endtask

  task automatic t_mirror();
    logic [31:0] v;
    cmdWr(9'h0, 8'h70);
    busRd(9'h0, 2'd2, v); chk("R7 wide mirror", v, 32'h00B0_00B0);
    busRd(9'h0, 2'd1, v); chk("R7 half no mirror", v, 32'h0000_00B0);
    busRd(9'h0, 2'd0, v); chk("R7 byte", v, 32'h0000_00B0);
    cmdWr(9'h0, 8'hFF);
  endtask

  task automatic t_ident();
    logic [31:0] v;
    cmdWr(9'h0, 8'h90);
    busRd(9'h000, 2'd1, v); chk("R8 maker code", v, 32'h1234);
    busRd(9'h003, 2'd1, v); chk("R8 index rounds down", v, 32'h1234);
    busRd(9'h004, 2'd1, v); chk("R8 device code", v, 32'h5678);
    busRd(9'h008, 2'd1, v); chk("R8 other index zero", v, 32'h0);
    cmdWr(9'h0, 8'hFF);
  endtask

  task automatic t_query();
    logic [31:0] v;
    cmdWr(9'h0, 8'h98);
    busRd(9'h040, 2'd0, v); chk("R9 Q", v, 32'h51);
    busRd(9'h044, 2'd0, v); chk("R9 R", v, 32'h52);
    busRd(9'h048, 2'd0, v); chk("R9 Y", v, 32'h59);
    busRd(9'h14C, 2'd0, v); chk("R9 beyond table", v, 32'h0);
    cmdWr(9'h0, 8'h77);
    busRd(9'h040, 2'd0, v); chk("R9 stays in query", v, 32'h51);
    cmdWr(9'h0, 8'hFF);
    busRd(9'h010, 2'd0, v); chk("R9 FF leaves query", v, 32'hA5);
  endtask

  task automatic t_unknown();
    logic [31:0] v;
    cmdWr(9'h0, 8'h70); cmdWr(9'h010, 8'h33);
    busRd(9'h010, 2'd0, v); chk("R12 unknown to array", v, 32'hA5);
    busRd(9'h080, 2'd2, v); chk("R12 storage untouched", v, ref32(9'h080));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 512; i++) refMem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_program();
    t_erase();
    t_buffer();
    t_clear();
    t_lock();
    t_readonly();
    t_mirror();
    t_ident();
    t_query();
    t_unknown();
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finishRun();
  end
endmodule